// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block takes over the job of retuning the clock-generator PLLs of a chip. A host asks for one or more of four PLLs to be retuned by raising `start` for one cycle with a mask of PLLs and one divider triple: reference divider NR, feedback multiplier NF and output divider NO. The sequencer checks the triple. For each selected PLL it moves that PLL's consumers onto the crystal (slow mode) and puts the PLL into reset. It then writes the encoded divider fields, holds reset for a settle time and releases it. Once the PLL reports lock it returns the PLL to normal mode.

The PLLs are indexed 0 (core), 1 (memory), 2 (codec) and 3 (general). The block drives each PLL's mode code, reset line and divider fields, and watches a 4-bit lock status word. A combinational readback port reports the frequency of any PLL from its mode and fields. A request ends with a one-cycle `done` pulse, or with a one-cycle `err` pulse when the triple is rejected or a PLL does not lock in time.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset, busy, done, err and every reset line are 0. Every mode code is slow (code 0), where normal is code 1 and deep is code 2. Every divider field is 0.
- R2: A PLL's mode code is slow whenever its reset line rises, so the mode is forced to slow before any divider is touched.
- R3: Divider fields hold value minus one: NR-1 in a 6-bit field, NF-1 in a 13-bit field, NO-1 in a 4-bit field. PLL i uses bits [i*W +: W] of each flattened field output.
- R4: With `req_bwadj`=1, the 12-bit bandwidth field of the PLL receives (NF>>1)-1. With `req_bwadj`=0, that field keeps its previous value.
- R5: Divider fields change only while the PLL's reset line is high. The reset line stays high for exactly SETTLE_CYC+1 cycles per programming.
- R6: After reset is released, the sequencer waits for the PLL's lock bit. The bits of `lock_stat` are ordered memory=0, core=1, codec=2, general=3. The mode returns to normal only in the cycle after lock is seen.
- R7: A request is rejected with an `err` pulse, and no mode, reset or field changes, when NR=0, NF<2, NO=0, NO>16, or NO is odd and not 1.
- R8: If lock is not seen within LOCK_TMO cycles, the sequence aborts with `err`. The PLL is left in slow mode with its reset released.
- R9: `busy` rises in the cycle after an accepted `start` and falls together with a one-cycle `done` or `err` pulse. A `start` while busy is ignored.
- R10: When several PLLs are selected in one request, they are programmed one at a time in ascending index order with the same triple.
- R11: The readback for PLL `rd_sel` reports OSC_HZ in slow mode and (OSC_MHz*NF/(NR*NO)) MHz, integer divided, in normal mode. Any other mode code reports 32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request strobe |
| req_mask | input | 4 | PLLs to program, bit i = PLL i |
| req_nr | input | 6 | Reference divider value |
| req_nf | input | 13 | Feedback multiplier value |
| req_no | input | 5 | Output divider value |
| req_bwadj | input | 1 | Write the bandwidth field |
| lock_stat | input | 4 | Lock bits: memory, core, codec, general |
| rd_sel | input | 2 | PLL selected for frequency readback |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle rejection/timeout pulse |
| pll_mode | output | 8 | 2-bit mode code per PLL |
| pll_rst | output | 4 | Reset line per PLL |
| cfg_nr | output | 24 | NR-1 field per PLL |
| cfg_nf | output | 52 | NF-1 field per PLL |
| cfg_no | output | 16 | NO-1 field per PLL |
| cfg_bw | output | 48 | Bandwidth field per PLL |
| rd_rate_hz | output | 40 | Readback frequency in Hz |

## Verification
A wrong sequencer state shows up at once at the ports. A PLL entering reset while still in normal mode, or a field moving while reset is low, can be seen in the same cycle. A wrong settle count changes the measured reset width within that one programming. A wrong lock-bit mapping or a bad ordering of multi-PLL requests shows in the order and the moment that mode codes turn normal, or as a spurious timeout LOCK_TMO cycles later. A wrong field encoding shows in the field outputs and the readback frequency as soon as `done` pulses.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

    localparam int NR_W   = 6;
    localparam int NF_W   = 13;
    localparam int NO_W   = 4;
    localparam int BW_W   = 12;
    localparam int RATE_W = 40;
    localparam int NO_MAX = 1 << NO_W;

    typedef enum logic [1:0] {
        MODE_SLOW   = 2'd0,
        MODE_NORMAL = 2'd1,
        MODE_DEEP   = 2'd2
    } pll_mode_e;

    typedef enum logic [3:0] {
        S_IDLE, S_PICK, S_SLOW, S_RST, S_PROG, S_SETTLE, S_LOCKW, S_DONE, S_FAIL
    } seq_state_e;

    typedef struct packed {
        logic [NR_W-1:0] nr;
        logic [NF_W-1:0] nf;
        logic [NO_W-1:0] no;
        logic [BW_W-1:0] bw;
    } div_cfg_t;

    // position of a PLL's lock flag in the lock status word
    function automatic int lock_pos(input int idx);
        case (idx)
            0:       return 1;
            1:       return 0;
            2:       return 2;
            default: return 3;
        endcase
    endfunction

    function automatic logic triple_ok(input logic [NR_W-1:0] nr,
                                       input logic [NF_W-1:0] nf,
                                       input logic [NO_W:0]   no);
        logic no_ok;
        no_ok = (no == 1) || (no != 0 && !no[0] && int'(no) <= NO_MAX);
        return (nr != 0) && (nf >= 2) && no_ok;
    endfunction

    function automatic div_cfg_t encode_div(input logic [NR_W-1:0] nr,
                                            input logic [NF_W-1:0] nf,
                                            input logic [NO_W:0]   no);
        div_cfg_t e;
        e.nr = nr - 1'b1;
        e.nf = nf - 1'b1;
        e.no = NO_W'(no - 1'b1);
        e.bw = BW_W'(nf >> 1) - 1'b1;
        return e;
    endfunction

endpackage

// File: rtl/pllseq_pick.sv
module pllseq_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     pend,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/pllseq_timer.sv
module pllseq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (dec)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/pllseq_cfgbank.sv
module pllseq_cfgbank
    import pllseq_pkg::*;
#(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic             bw_we,
    input  div_cfg_t         din,
    output div_cfg_t         regs [N]
);
    for (genvar i = 0; i < N; i++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (we && widx == IDX_W'(i)) begin
                regs[i].nr <= din.nr;
                regs[i].nf <= din.nf;
                regs[i].no <= din.no;
                if (bw_we) regs[i].bw <= din.bw;
            end
        end
    end
endmodule

// File: rtl/pllseq_rate.sv
module pllseq_rate
    import pllseq_pkg::*;
#(
    parameter int OSC_HZ = 24_000_000
) (
    input  pll_mode_e         mode,
    input  div_cfg_t          cfg,
    output logic [RATE_W-1:0] rate_hz
);
    localparam int OSC_MHZ = OSC_HZ / 1_000_000;

    logic [31:0] num, den, quo;

    always_comb begin
        num = 32'(OSC_MHZ) * (32'(cfg.nf) + 32'd1);
        den = (32'(cfg.nr) + 32'd1) * (32'(cfg.no) + 32'd1);
        quo = num / den;
        case (mode)
            MODE_SLOW:   rate_hz = RATE_W'(OSC_HZ);
            MODE_NORMAL: rate_hz = RATE_W'(quo) * RATE_W'(1_000_000);
            default:     rate_hz = RATE_W'(32768);
        endcase
    end
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
    import pllseq_pkg::*;
#(
    parameter int NPLL       = 4,
    parameter int SETTLE_CYC = 240,
    parameter int LOCK_TMO   = 100_000,
    parameter int OSC_HZ     = 24_000_000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [NPLL-1:0]        req_mask,
    input  logic [NR_W-1:0]        req_nr,
    input  logic [NF_W-1:0]        req_nf,
    input  logic [NO_W:0]          req_no,
    input  logic                   req_bwadj,
    input  logic [NPLL-1:0]        lock_stat,
    input  logic [$clog2(NPLL)-1:0] rd_sel,
    output logic                   busy,
    output logic                   done,
    output logic                   err,
    output logic [2*NPLL-1:0]      pll_mode,
    output logic [NPLL-1:0]        pll_rst,
    output logic [NPLL*NR_W-1:0]   cfg_nr,
    output logic [NPLL*NF_W-1:0]   cfg_nf,
    output logic [NPLL*NO_W-1:0]   cfg_no,
    output logic [NPLL*BW_W-1:0]   cfg_bw,
    output logic [RATE_W-1:0]      rd_rate_hz
);
    localparam int IDX_W   = $clog2(NPLL);
    localparam int TMR_MAX = (SETTLE_CYC > LOCK_TMO) ? SETTLE_CYC : LOCK_TMO;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    seq_state_e       state_q;
    logic [IDX_W-1:0] cur_q;
    logic [NPLL-1:0]  pend_q;
    div_cfg_t         req_q;
    logic             bwadj_q;
    pll_mode_e        mode_q [NPLL];
    logic [NPLL-1:0]  rst_q;
    logic             busy_q, done_q, err_q;

    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;
    logic             t_load, t_dec, t_zero;
    logic [TMR_W-1:0] t_val;
    logic             lock_now;
    div_cfg_t         bank [NPLL];

    pllseq_pick #(.N(NPLL), .IDX_W(IDX_W)) u_pick (
        .pend(pend_q), .any(pick_any), .idx(pick_idx)
    );

    always_comb begin
        t_load = (state_q == S_PROG) || (state_q == S_SETTLE && t_zero);
        t_val  = (state_q == S_PROG) ? TMR_W'(SETTLE_CYC - 1) : TMR_W'(LOCK_TMO - 1);
        t_dec  = (state_q == S_SETTLE || state_q == S_LOCKW) && !t_zero;
    end

    pllseq_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val),
        .dec(t_dec), .zero(t_zero)
    );

    pllseq_cfgbank #(.N(NPLL), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst(rst), .we(state_q == S_PROG), .widx(cur_q),
        .bw_we(bwadj_q), .din(req_q), .regs(bank)
    );

    assign lock_now = lock_stat[lock_pos(int'(cur_q))];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cur_q   <= '0;
            pend_q  <= '0;
            req_q   <= '0;
            bwadj_q <= 1'b0;
            rst_q   <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            for (int i = 0; i < NPLL; i++) mode_q[i] <= MODE_SLOW;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state_q)
                S_IDLE: if (start) begin
                    busy_q  <= 1'b1;
                    pend_q  <= req_mask;
                    req_q   <= encode_div(req_nr, req_nf, req_no);
                    bwadj_q <= req_bwadj;
                    state_q <= triple_ok(req_nr, req_nf, req_no) ? S_PICK : S_FAIL;
                end
                S_PICK: if (pick_any) begin
                    cur_q   <= pick_idx;
                    state_q <= S_SLOW;
                end else begin
                    state_q <= S_DONE;
                end
                S_SLOW: begin
                    mode_q[cur_q] <= MODE_SLOW;
                    state_q       <= S_RST;
                end
                S_RST: begin
                    rst_q[cur_q] <= 1'b1;
                    state_q      <= S_PROG;
                end
                S_PROG:   state_q <= S_SETTLE;
                S_SETTLE: if (t_zero) begin
                    rst_q[cur_q] <= 1'b0;
                    state_q      <= S_LOCKW;
                end
                S_LOCKW: if (lock_now) begin
                    mode_q[cur_q] <= MODE_NORMAL;
                    pend_q[cur_q] <= 1'b0;
                    state_q       <= S_PICK;
                end else if (t_zero) begin
                    state_q <= S_FAIL;
                end
                S_DONE: begin
                    done_q  <= 1'b1;
                    busy_q  <= 1'b0;
                    state_q <= S_IDLE;
                end
                S_FAIL: begin
                    err_q   <= 1'b1;
                    busy_q  <= 1'b0;
                    state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    for (genvar i = 0; i < NPLL; i++) begin : g_out
        assign pll_mode[2*i +: 2]       = mode_q[i];
        assign cfg_nr[i*NR_W +: NR_W]   = bank[i].nr;
        assign cfg_nf[i*NF_W +: NF_W]   = bank[i].nf;
        assign cfg_no[i*NO_W +: NO_W]   = bank[i].no;
        assign cfg_bw[i*BW_W +: BW_W]   = bank[i].bw;

        // R2: reset only ever rises on a PLL already in slow mode
        p_slow_at_reset_r2: assert property (@(posedge clk) disable iff (rst)
            $rose(rst_q[i]) |-> mode_q[i] == MODE_SLOW);

        // R5: divider fields move only while the PLL is held in reset
        p_fields_in_reset_r5: assert property (@(posedge clk) disable iff (rst)
            !rst_q[i] |=> $stable(bank[i]));

        // R6: normal mode follows a seen lock flag
        p_normal_after_lock_r6: assert property (@(posedge clk) disable iff (rst)
            (mode_q[i] == MODE_NORMAL && $past(mode_q[i]) != MODE_NORMAL)
            |-> $past(lock_stat[lock_pos(i)]));
    end

    // R10: at most one PLL in reset at any time
    p_one_in_reset_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rst_q));

    // R9: busy ends only with a completion pulse, never both pulses at once
    p_busy_end_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> (done_q ^ err_q));

    pllseq_rate #(.OSC_HZ(OSC_HZ)) u_rate (
        .mode(mode_q[rd_sel]), .cfg(bank[rd_sel]), .rate_hz(rd_rate_hz)
    );

    assign pll_rst = rst_q;
    assign busy    = busy_q;
    assign done    = done_q;
    assign err     = err_q;
endmodule

// File: tb/tb_pll_reprog_seq.sv
module tb_pll_reprog_seq;
    localparam int SETTLE  = 4;
    localparam int TMO     = 50;
    localparam int LK_DLY  = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  req_mask = '0;
    logic [5:0]  req_nr = '0;
    logic [12:0] req_nf = '0;
    logic [4:0]  req_no = '0;
    logic        req_bwadj = 1'b0;
    logic [3:0]  lock_stat;
    logic [1:0]  rd_sel = '0;
    logic        busy, done, err;
    logic [7:0]  pll_mode;
    logic [3:0]  pll_rst;
    logic [23:0] cfg_nr;
    logic [51:0] cfg_nf;
    logic [15:0] cfg_no;
    logic [47:0] cfg_bw;
    logic [39:0] rd_rate_hz;

    always #2 clk = ~clk;

    pll_reprog_seq #(.SETTLE_CYC(SETTLE), .LOCK_TMO(TMO)) dut (
        .clk(clk), .rst(rst), .start(start), .req_mask(req_mask),
        .req_nr(req_nr), .req_nf(req_nf), .req_no(req_no), .req_bwadj(req_bwadj),
        .lock_stat(lock_stat), .rd_sel(rd_sel), .busy(busy), .done(done), .err(err),
        .pll_mode(pll_mode), .pll_rst(pll_rst), .cfg_nr(cfg_nr), .cfg_nf(cfg_nf),
        .cfg_no(cfg_no), .cfg_bw(cfg_bw), .rd_rate_hz(rd_rate_hz)
    );

    int n_chk = 0, n_bad = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // PLL model and port monitors
    logic [3:0] lk = 4'hF, dead = 4'h0, prev_rst = 4'h0;
    int lk_cnt [4], run_len [4], last_len [4];
    int slow_viol = 0;
    int order_log [8];
    int order_n = 0;
    logic [7:0] prev_mode = '0;
    assign lock_stat = {lk[3], lk[2], lk[0], lk[1]};

    initial begin
        for (int i = 0; i < 4; i++) begin lk_cnt[i] = 0; run_len[i] = 0; last_len[i] = 0; end
        forever begin
            @(negedge clk);
            for (int i = 0; i < 4; i++) begin
                if (pll_rst[i]) begin
                    if (!prev_rst[i] && pll_mode[2*i +: 2] != 2'd0) slow_viol++;
                    lk[i] = 1'b0;
                    lk_cnt[i] = LK_DLY;
                    run_len[i]++;
                end else begin
                    if (prev_rst[i]) begin last_len[i] = run_len[i]; run_len[i] = 0; end
                    if (lk_cnt[i] > 0) begin
                        lk_cnt[i]--;
                        if (lk_cnt[i] == 0) lk[i] = 1'b1;
                    end
                end
                if (dead[i]) lk[i] = 1'b0;
                if (pll_mode[2*i +: 2] == 2'd1 && prev_mode[2*i +: 2] != 2'd1 && order_n < 8) begin
                    order_log[order_n] = i;
                    order_n++;
                end
            end
            prev_rst  = pll_rst;
            prev_mode = pll_mode;
        end
    end

    logic got_done, got_err;

    task automatic issue(input logic [3:0] m, input logic [5:0] nr, input logic [12:0] nf,
                         input logic [4:0] no, input logic bw);
        @(negedge clk);
        start = 1'b1; req_mask = m; req_nr = nr; req_nf = nf; req_no = no; req_bwadj = bw;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end();
        got_done = 1'b0; got_err = 1'b0;
        for (int k = 0; k < 3000; k++) begin
            if (done || err) begin got_done = done; got_err = err; break; end
            @(negedge clk);
        end
    endtask

    typedef struct packed {
        logic [1:0]  idx;
        logic [5:0]  nr;
        logic [12:0] nf;
        logic [4:0]  no;
        logic        bw_en;
        logic [39:0] rate;
        logic [11:0] bw;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{2'd0, 6'd1, 13'd50,  5'd2, 1'b1, 40'd600_000_000,  12'd24},
        '{2'd0, 6'd1, 13'd59,  5'd1, 1'b1, 40'd1416_000_000, 12'd28},
        '{2'd1, 6'd2, 13'd25,  5'd1, 1'b1, 40'd300_000_000,  12'd11},
        '{2'd1, 6'd9, 13'd400, 5'd2, 1'b1, 40'd533_000_000,  12'd199},
        '{2'd3, 6'd2, 13'd100, 5'd2, 1'b1, 40'd600_000_000,  12'd49},
        '{2'd2, 6'd3, 13'd100, 5'd1, 1'b0, 40'd800_000_000,  12'd0},
        '{2'd1, 6'd2, 13'd25,  5'd1, 1'b0, 40'd300_000_000,  12'd199}
    };

    initial begin
        for (int c = 0; c < 150_000; c++) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R9: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", 64'(busy), 0);
        chk("R1 done/err", 64'({done, err}), 0);
        chk("R1 modes", 64'(pll_mode), 0);
        chk("R1 resets", 64'(pll_rst), 0);
        chk("R1 fields", 64'(cfg_nr) | 64'(cfg_no) | 64'(cfg_nf) | 64'(cfg_bw), 0);
        rd_sel = 2'd2; #1;
        chk("R11 slow readback", 64'(rd_rate_hz), 24_000_000);

        // table walk: R3 R4 R5 R6 R11
        for (int v = 0; v < 7; v++) begin
            int ix;
            ix = int'(VECS[v].idx);
            issue(4'b0001 << ix, VECS[v].nr, VECS[v].nf, VECS[v].no, VECS[v].bw_en);
            chk("R9 busy after accept", 64'(busy), 1);
            wait_end();
            chk("R6 done", 64'({got_done, got_err}), 2);
            chk("R3 nr field", 64'(cfg_nr[ix*6 +: 6]), 64'(VECS[v].nr - 6'd1));
            chk("R3 nf field", 64'(cfg_nf[ix*13 +: 13]), 64'(VECS[v].nf - 13'd1));
            chk("R3 no field", 64'(cfg_no[ix*4 +: 4]), 64'(VECS[v].no - 5'd1));
            chk("R4 bw field", 64'(cfg_bw[ix*12 +: 12]), 64'(VECS[v].bw));
            chk("R6 mode normal", 64'(pll_mode[ix*2 +: 2]), 1);
            chk("R5 reset width", 64'(last_len[ix]), SETTLE + 1);
            rd_sel = VECS[v].idx; #1;
            chk("R11 rate", 64'(rd_rate_hz), 64'(VECS[v].rate));
            @(negedge clk);
            chk("R9 done one cycle", 64'({done, busy}), 0);
        end
        chk("R2 slow before reset", 64'(slow_viol), 0);

        // R10 two PLLs in one request
        order_n = 0;
        issue(4'b1010, 6'd1, 13'd50, 5'd2, 1'b1);
        wait_end();
        chk("R10 done", 64'(got_done), 1);
        chk("R10 count", 64'(order_n), 2);
        chk("R10 first", 64'(order_log[0]), 1);
        chk("R10 second", 64'(order_log[1]), 3);
        chk("R10 fields pll3", 64'(cfg_nf[3*13 +: 13]), 49);

        // R9 start while busy is ignored
        issue(4'b0001, 6'd1, 13'd50, 5'd2, 1'b1);
        @(negedge clk);
        chk("R9 busy", 64'(busy), 1);
        start = 1'b1; req_mask = 4'b0100; req_nr = 6'd5; req_nf = 13'd77; req_no = 5'd4;
        @(negedge clk);
        start = 1'b0;
        wait_end();
        chk("R9 first ends ok", 64'({got_done, got_err}), 2);
        chk("R9 ignored nr", 64'(cfg_nr[2*6 +: 6]), 2);
        chk("R9 ignored nf", 64'(cfg_nf[2*13 +: 13]), 99);
        repeat (SETTLE + 4) @(negedge clk);
        chk("R9 no second run", 64'({busy, pll_rst}), 0);

        // R7 rejected triples
        issue(4'b1000, 6'd1, 13'd50, 5'd3, 1'b1);
        wait_end();
        chk("R7 odd NO err", 64'({got_done, got_err}), 1);
        chk("R7 fields kept", 64'(cfg_no[3*4 +: 4]), 1);
        chk("R7 mode kept", 64'(pll_mode[3*2 +: 2]), 1);
        @(negedge clk);
        chk("R7 busy low", 64'(busy), 0);
        issue(4'b1000, 6'd1, 13'd50, 5'd18, 1'b1);
        wait_end();
        chk("R7 NO>16 err", 64'(got_err), 1);
        issue(4'b1000, 6'd0, 13'd50, 5'd2, 1'b1);
        wait_end();
        chk("R7 NR=0 err", 64'(got_err), 1);
        chk("R7 reset untouched", 64'(pll_rst), 0);

        // R8 lock timeout
        dead[2] = 1'b1;
        issue(4'b0100, 6'd1, 13'd50, 5'd2, 1'b1);
        wait_end();
        chk("R8 timeout err", 64'({got_done, got_err}), 1);
        chk("R8 left slow", 64'(pll_mode[2*2 +: 2]), 0);
        chk("R8 reset released", 64'(pll_rst[2]), 0);
        rd_sel = 2'd2; #1;
        chk("R11 slow after abort", 64'(rd_rate_hz), 24_000_000);
        @(negedge clk);
        chk("R8 busy low", 64'(busy), 0);
        dead[2] = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule